// File: doc/BRIEF.md
# Carry-Skip Adder

This block is a purely combinational unsigned adder. It takes two operands, possibly of different widths, and returns their sum one bit wider than the wider operand. The top bit of the result is the carry-out. Before the addition, the narrower operand is widened with zeros.

The operand bits are grouped into fixed-size segments, starting from the least significant bit. Inside each segment the carry ripples from bit to bit. Each segment also has a bypass multiplexer. When every bit pair in the segment has exactly one operand bit set, the multiplexer passes the segment's incoming carry straight to the next segment and does not wait for the ripple. The segment size is a parameter, and the width does not have to be a multiple of it. When the width is not a multiple, the top segment covers only the bits that are left over.

Top module: `csk_adder`

## Requirements
- R1: `result[N-1:0]` equals the low N bits of the unsigned sum of the two operands, where N is the larger of the two operand widths.
- R2: `result[N]` is the carry-out of that N-bit unsigned sum.
- R3: The narrower operand is zero-extended, so its missing upper bits count as 0.
- R4: The carry into the lowest segment is fixed at 0, so bit 0 is formed by a half adder. With both operands zero, the result is 0.
- R5: When every bit of a segment has operand bits that differ, the carry out of that segment equals the carry into it, and its ripple carry agrees.
- R6: When a segment bypasses, every sum bit in that segment equals the inverse of the segment's carry-in.
- R7: When N is not a multiple of the segment size, the top segment is shorter and still adds correctly.
- R8: The sum is correct for N=1 and for a segment size larger than N, where the adder is a single segment.
- R9: All-ones plus all-ones gives all-ones shifted left by one. All-ones plus one gives `result` = 1 followed by N zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | WA | First unsigned operand |
| b_in | input | WB | Second unsigned operand |
| result | output | N+1 | Sum in bits N-1..0, carry-out in bit N (N = max(WA, WB)) |

## Verification
The hardest condition to reach is a carry of 1 that travels the whole width through the bypass multiplexers. For that, bit 0 must generate a carry and every higher bit must propagate. Random operands almost never do both at once. Directed patterns therefore build this case on purpose: one operand has alternating ones and zeros, and the other is its complement plus one. Further directed cases force the short top segment and the single-segment configurations, and these are checked alongside the random sums.

// File: rtl/csk_pkg.sv
// Package: shared helpers for the carry-skip adder.
// Assumes segment size >= 1 and operand width >= 1.
package csk_pkg;

    // Number of segments needed to cover n bits with segments of size s.
    function automatic int csk_seg_count(input int n, input int s);
        return (n + s - 1) / s;
    endfunction

    // Lowest bit index of segment k.
    function automatic int csk_seg_lo(input int k, input int s);
        return k * s;
    endfunction

    // Width of segment k; the top segment may be shorter than s.
    function automatic int csk_seg_width(input int k, input int s, input int n);
        int rem;
        rem = n - k * s;
        return (rem < s) ? rem : s;
    endfunction

endpackage

// File: rtl/csk_half_add.sv
// Module: one-bit half adder, used only at bit 0, where the carry-in is fixed at 0.
// Assumes nothing beyond single-bit inputs.
module csk_half_add (
    input  logic x,
    input  logic y,
    output logic s,
    output logic co
);
    // Sum and carry of two bits.
    always_comb begin
        s  = x ^ y;
        co = x & y;
    end
endmodule

// File: rtl/csk_full_add.sv
// Module: one-bit full adder, used in every ripple position except bit 0.
// Assumes single-bit inputs.
module csk_full_add (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    logic p;

    // Sum and majority carry of three bits.
    always_comb begin
        p  = x ^ y;
        s  = p ^ ci;
        co = (x & y) | (p & ci);
    end
endmodule

// File: rtl/csk_segment.sv
// Module: one carry-skip segment, which ripples W bits and has a bypass multiplexer.
// Assumes W >= 1. LOWEST selects a half adder at the segment's bit 0.
// seg_ripple is the carry that ripples out of the segment's top bit. seg_co is the
// multiplexer output: seg_ci when all bits propagate, otherwise seg_ripple.
module csk_segment #(
    parameter int W      = 4,
    parameter bit LOWEST = 1'b0
) (
    input  logic [W-1:0] seg_a,
    input  logic [W-1:0] seg_b,
    input  logic         seg_ci,
    output logic [W-1:0] seg_sum,
    output logic         seg_ripple,
    output logic         seg_skip,
    output logic         seg_co
);
    logic [W:1]   chain;
    logic [W-1:0] prop;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            if (i == 0) begin : g_first
                if (LOWEST) begin : g_half
                    csk_half_add u_ha (
                        .x (seg_a[0]),
                        .y (seg_b[0]),
                        .s (seg_sum[0]),
                        .co(chain[1])
                    );
                end else begin : g_full
                    csk_full_add u_fa (
                        .x (seg_a[0]),
                        .y (seg_b[0]),
                        .ci(seg_ci),
                        .s (seg_sum[0]),
                        .co(chain[1])
                    );
                end
            end else begin : g_rest
                csk_full_add u_fa (
                    .x (seg_a[i]),
                    .y (seg_b[i]),
                    .ci(chain[i]),
                    .s (seg_sum[i]),
                    .co(chain[i+1])
                );
            end
        end
    endgenerate

    // Propagate terms, the segment-wide AND, and the bypass multiplexer.
    always_comb begin
        prop       = seg_a ^ seg_b;
        seg_skip   = &prop;
        seg_ripple = chain[W];
        seg_co     = seg_skip ? seg_ci : chain[W];
    end
endmodule

// File: rtl/csk_adder.sv
// Module: top-level unsigned carry-skip adder.
// Assumes WA, WB, SEG >= 1. The narrower operand is zero-extended to N = max(WA, WB).
// This is pure combinational logic with no clock or reset. result[N] is the carry
// out of the last segment's multiplexer.
module csk_adder #(
    parameter int WA  = 16,
    parameter int WB  = 11,
    parameter int SEG = 4,
    localparam int N  = (WA > WB) ? WA : WB
) (
    input  logic [WA-1:0] a_in,
    input  logic [WB-1:0] b_in,
    output logic [N:0]    result
);
    import csk_pkg::*;

    localparam int NSEG = csk_seg_count(N, SEG);

    logic [N-1:0]  opa;
    logic [N-1:0]  opb;
    logic [N-1:0]  sum_bits;
    logic [NSEG:0] blk_carry;
    logic [NSEG-1:0] blk_skip;
    logic [NSEG-1:0] blk_ripple;

    // Zero-extend both operands to the common width.
    always_comb begin
        opa = N'(a_in);
        opb = N'(b_in);
    end

    assign blk_carry[0] = 1'b0;

    genvar k;
    generate
        for (k = 0; k < NSEG; k++) begin : g_seg
            localparam int LO = csk_seg_lo(k, SEG);
            localparam int SW = csk_seg_width(k, SEG, N);
            csk_segment #(
                .W     (SW),
                .LOWEST(k == 0)
            ) u_seg (
                .seg_a     (opa[LO +: SW]),
                .seg_b     (opb[LO +: SW]),
                .seg_ci    (blk_carry[k]),
                .seg_sum   (sum_bits[LO +: SW]),
                .seg_ripple(blk_ripple[k]),
                .seg_skip  (blk_skip[k]),
                .seg_co    (blk_carry[k+1])
            );
        end
    endgenerate

    assign result = {blk_carry[NSEG], sum_bits};
endmodule

// File: rtl/csk_adder_chk.sv
// Module: assertion checker for csk_adder, attached to it by bind.
// Assumes the top's internal segment carry, skip and ripple vectors are visible by name.
// Immediate assertions are evaluated on settled combinational values.
module csk_adder_chk #(
    parameter int WA  = 16,
    parameter int WB  = 11,
    parameter int SEG = 4,
    localparam int N  = (WA > WB) ? WA : WB,
    localparam int NSEG = (N + SEG - 1) / SEG
) (
    input logic [WA-1:0]   a_in,
    input logic [WB-1:0]   b_in,
    input logic [N:0]      result,
    input logic [NSEG:0]   blk_carry,
    input logic [NSEG-1:0] blk_skip,
    input logic [NSEG-1:0] blk_ripple
);
    logic [N:0] ref_sum;

    // Arithmetic reference computed from the zero-extended ports.
    always_comb ref_sum = (N+1)'(a_in) + (N+1)'(b_in);

    // Sum bits and carry-out against the reference.
    always_comb begin
        assert_sum_bits_R1: assert (result[N-1:0] == ref_sum[N-1:0])
            else $error("sum bits %h, expected %h", result[N-1:0], ref_sum[N-1:0]);
        assert_carry_out_R2: assert (result[N] == ref_sum[N])
            else $error("carry-out %b, expected %b", result[N], ref_sum[N]);
    end

    genvar k;
    generate
        for (k = 0; k < NSEG; k++) begin : g_seg_chk
            localparam int LO = k * SEG;
            localparam int SW = ((N - LO) < SEG) ? (N - LO) : SEG;
            // Checks on the bypass path of this segment.
            always_comb begin
                assert_bypass_ripple_R5: assert (!blk_skip[k] || (blk_ripple[k] == blk_carry[k]))
                    else $error("segment %0d ripple disagrees with bypass", k);
                assert_bypass_sum_R6: assert (!blk_skip[k] ||
                                              (result[LO +: SW] == {SW{~blk_carry[k]}}))
                    else $error("segment %0d bypass sum wrong", k);
            end
        end
    endgenerate
endmodule

bind csk_adder csk_adder_chk #(.WA(WA), .WB(WB), .SEG(SEG)) u_chk (
    .a_in      (a_in),
    .b_in      (b_in),
    .result    (result),
    .blk_carry (blk_carry),
    .blk_skip  (blk_skip),
    .blk_ripple(blk_ripple)
);

// File: tb/sim_csk_adder.sv
// Bench: drives four adder configurations and compares each with a bench-side sum.
module sim_csk_adder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    // u0: N=16, 4 segments, b zero-extended from 11 bits
    logic [15:0] a0;  logic [10:0] b0;  logic [16:0] r0;
    // u1: N=1
    logic [0:0]  a1;  logic [0:0]  b1;  logic [1:0]  r1;
    // u2: N=7, segment size 3, short top segment
    logic [6:0]  a2;  logic [6:0]  b2;  logic [7:0]  r2;
    // u3: segment size 8 larger than N=5, b from 3 bits
    logic [4:0]  a3;  logic [2:0]  b3;  logic [5:0]  r3;

    csk_adder #(.WA(16), .WB(11), .SEG(4)) u0 (.a_in(a0), .b_in(b0), .result(r0));
    csk_adder #(.WA(1),  .WB(1),  .SEG(4)) u1 (.a_in(a1), .b_in(b1), .result(r1));
    csk_adder #(.WA(7),  .WB(7),  .SEG(3)) u2 (.a_in(a2), .b_in(b2), .result(r2));
    csk_adder #(.WA(5),  .WB(3),  .SEG(8)) u3 (.a_in(a3), .b_in(b3), .result(r3));

    // Expected sums from plain arithmetic on zero-extended operands.
    function automatic logic [16:0] exp0(input logic [15:0] a, input logic [10:0] b);
        return {1'b0, a} + {6'b0, b};
    endfunction
    function automatic logic [7:0] exp2(input logic [6:0] a, input logic [6:0] b);
        return {1'b0, a} + {1'b0, b};
    endfunction
    function automatic logic [5:0] exp3(input logic [4:0] a, input logic [2:0] b);
        return {1'b0, a} + {3'b0, b};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply operands on a rising edge, then compare on the following falling edge.
    task automatic apply(input logic [15:0] va0, input logic [10:0] vb0,
                         input logic [6:0] va2, input logic [6:0] vb2,
                         input logic [4:0] va3, input logic [2:0] vb3,
                         input logic va1, input logic vb1, input string req);
        @(posedge clk);
        a0 = va0; b0 = vb0; a2 = va2; b2 = vb2; a3 = va3; b3 = vb3;
        a1 = va1; b1 = vb1;
        @(negedge clk);
        chk({req, " u0"}, 32'(r0), 32'(exp0(va0, vb0)));
        chk({req, " u1"}, 32'(r1), 32'({1'b0, va1} + {1'b0, vb1}));
        chk({req, " u2"}, 32'(r2), 32'(exp2(va2, vb2)));
        chk({req, " u3"}, 32'(r3), 32'(exp3(va3, vb3)));
    endtask

    initial begin
        a0 = '0; b0 = '0; a1 = '0; b1 = '0; a2 = '0; b2 = '0; a3 = '0; b3 = '0;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: zero operands give a zero result
        chk("R4 zero u0", 32'(r0), 32'h0);
        chk("R4 zero u2", 32'(r2), 32'h0);
        // R3: wide b all ones, a zero, so the upper bits come from zero extension
        apply(16'h0, 11'h7FF, 7'h0, 7'h7F, 5'h0, 3'h7, 1'b0, 1'b1, "R3 extend");
        chk("R3 u0 value", 32'(r0), 32'h007FF);
        // R9: all-ones plus one; u0 uses b=1
        apply(16'hFFFF, 11'h1, 7'h7F, 7'h1, 5'h1F, 3'h1, 1'b1, 1'b1, "R9 ones+1");
        chk("R9 u0 ones+1", 32'(r0), 32'h10000);
        chk("R8 u1 1+1", 32'(r1), 32'h2);
        // R9: all-ones plus all-ones on the equal-width instance
        apply(16'hFFFF, 11'h7FF, 7'h7F, 7'h7F, 5'h1F, 3'h7, 1'b1, 1'b1, "R9 ones+ones");
        chk("R9 u2 ones+ones", 32'(r2), 32'hFE);
        // R5, R6: every bit propagates, carry-in 0, so all sum bits are 1 and there is no carry
        apply(16'hAAAA, 11'h555, 7'h2A, 7'h55, 5'h0A, 3'h5, 1'b1, 1'b0, "R6 all-prop");
        chk("R5 u2 all-prop", 32'(r2), 32'h7F);
        // R5: bit 0 generates, everything above propagates, so the carry bypasses every segment
        apply(16'h5555, 11'h2AB, 7'h55, 7'h2B, 5'h15, 3'h3, 1'b1, 1'b1, "R5 skip chain");
        chk("R5 u2 skip chain", 32'(r2), 32'h80);
        // R7: short top segment of u2 (bit 6) generates its own carry
        apply(16'h8000, 11'h0, 7'h40, 7'h40, 5'h10, 3'h0, 1'b0, 1'b0, "R7 top seg");
        chk("R7 u2 top seg", 32'(r2), 32'h80);
        // R8: single segment larger than N
        apply(16'h1234, 11'h0CD, 7'h33, 7'h0C, 5'h1D, 3'h6, 1'b0, 1'b1, "R8 single seg");
        chk("R8 u3 single seg", 32'(r3), 32'h23);
        // R1, R2: random operands
        for (int i = 0; i < 400; i++) begin
            apply(16'($urandom), 11'($urandom), 7'($urandom), 7'($urandom),
                  5'($urandom), 3'($urandom), 1'($urandom), 1'($urandom), "R1 R2 random");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule